// File: doc/BRIEF.md
# Bipolar Line Encoder with Test Error Injection

This block sits on the transmit side of a serial line. Each cycle in which `in_valid` is high it takes one bit of a unipolar stream. It produces a dual-rail bipolar code on two pulse lines, one positive and one negative. Marks alternate in polarity. Zero runs can be replaced by substitution codes that contain a deliberate violation, so that the receiver keeps enough transitions: a three-zero code for the lower-rate mode and a four-zero code for the higher-rate mode. `line_hdb3` selects between the two. A configuration bit can switch substitution off so that only plain alternating marks are sent.

For line testing, the block can corrupt the stream on purpose. It can send a mark with the wrong polarity, or it can let one zero run through without substitution so that the far end sees an excessive-zero event. A request for corruption comes from one of two sources, chosen by a configuration bit: a rising edge of a register bit, or an external manual-insert pin. The request is held until the next place in the stream where the error can be applied.

A five-bit configuration register is written through `cfg_we`/`cfg_wdata` and read back on `cfg_rdata`. Its bit positions are: bit 4 turns substitution off, bit 3 enables excessive-zero injection, bit 2 enables violation injection, bit 1 is the software request bit, and bit 0 selects the pin as the request source.

Top module: `bipolar_line_encoder`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `out_valid`, `pos_out` and `neg_out` are low, and the delay line holds idle zero slots that are never substituted.
- R2: A write with `cfg_we` high stores `cfg_wdata[4:0]` on the next edge. `cfg_rdata` returns those five bits, and every bit above bit 4 reads 0.
- R3: Each cycle with `in_valid` high produces one output symbol on the following cycle, flagged by `out_valid`. That symbol belongs to the bit accepted 3 (three-zero mode, `line_hdb3`=0) or 4 (four-zero mode, `line_hdb3`=1) valid cycles earlier, and the first 3 or 4 symbols after reset carry no pulse. `pos_out` and `neg_out` are never high together and are both low when `out_valid` is low.
- R4: With bit 4 set, a 1 becomes a pulse of the opposite polarity to the previous pulse and a 0 becomes no pulse, whatever the length of the zero run. The first pulse after reset is positive.
- R5: With bit 4 clear and `line_hdb3`=0, every run of three zeros becomes 00V when the number of pulses since the last V is odd, and B0V when it is even. B takes the opposite polarity to the previous pulse, and V takes the same polarity as the previous pulse.
- R6: With bit 4 clear and `line_hdb3`=1, every run of four zeros becomes 000V or B00V under the same odd-count rule.
- R7: A pending violation request with bit 2 set makes the next data mark go out with the same polarity as the previous pulse, and is then cleared.
- R8: A pending excessive-zero request with bit 3 set leaves the next zero run that would have been substituted as raw zeros on the line, and is then cleared.
- R9: With bit 0 clear, a 0-to-1 change of bit 1 raises a request. Several rises before the error is applied give only one error.
- R10: With bit 0 set, a rising edge of `manual_err` raises a request. With bit 0 clear, `manual_err` has no effect.
- R11: A request made while bits 2 and 3 are both clear leaves the line code unchanged.
- R12: A change of bit 0 while the newly selected source is high counts as a rising request.
- R13: With bits 2 and 3 both set, one request yields both a violation and an excessive-zero event, each at its own next opportunity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data (bits 4:0 used) |
| cfg_rdata | output | CFG_W | Configuration readback, upper bits zero |
| line_hdb3 | input | 1 | 0: three-zero substitution, 1: four-zero substitution |
| manual_err | input | 1 | External error-insert request |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Unipolar data bit |
| pos_out | output | 1 | Positive pulse rail |
| neg_out | output | 1 | Negative pulse rail |
| out_valid | output | 1 | Output symbol strobe |

## Verification
The bench drives zero runs of several lengths and with both odd and even pulse counts since the last violation. A parity rule applied the wrong way round would put B where 00V belongs, and would then show up as two same-polarity pulses in the wrong place. It toggles the software request bit several times before any stream starts: a design that counted edges instead of latching one request would corrupt a second mark. It also flips the source select while the pin is held high, and pulses the pin while it is not selected. Both cases show whether the request edge is taken after the source mux or at only one source. An excessive-zero request is followed by further zero runs, which shows whether the raw run is protected from being substituted later at a shifted position.

// File: rtl/ble_pkg.sv
`timescale 1ns/1ps
package ble_pkg;
  // symbol kinds held in the delay line
  typedef enum logic [2:0] {
    SYM_HOLD = 3'd0,  // zero that may not be substituted
    SYM_ZERO = 3'd1,  // plain zero, candidate for substitution
    SYM_MARK = 3'd2,  // data one
    SYM_BIP  = 3'd3,  // balancing pulse of a substitution code
    SYM_VIOL = 3'd4   // violation pulse of a substitution code
  } sym_t;

  localparam int CFG_FIELDS = 5;
  localparam int F_MSEL = 0;
  localparam int F_SREQ = 1;
  localparam int F_BPV  = 2;
  localparam int F_EXZ  = 3;
  localparam int F_ZOFF = 4;
  localparam int LINE_DEPTH = 4;
endpackage

// File: rtl/ble_ctrl.sv
`timescale 1ns/1ps
module ble_ctrl
  import ble_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             manual_err,
  input  logic             bpv_take,
  input  logic             exz_take,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             zs_off,
  output logic             bpv_arm,
  output logic             exz_arm
);
  logic [CFG_FIELDS-1:0] cfg_q;
  logic req_prev, bpv_pend, exz_pend;
  logic req_src, req_rise;

  logic unused_wr_hi;
  assign unused_wr_hi = ^cfg_wdata[CFG_W-1:CFG_FIELDS];

  // edge detection is done after the source mux
  assign req_src  = cfg_q[F_MSEL] ? manual_err : cfg_q[F_SREQ];
  assign req_rise = req_src & ~req_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      req_prev <= 1'b0;
      bpv_pend <= 1'b0;
      exz_pend <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata[CFG_FIELDS-1:0];
      req_prev <= req_src;
      bpv_pend <= (bpv_pend & ~bpv_take) | (req_rise & cfg_q[F_BPV]);
      exz_pend <= (exz_pend & ~exz_take) | (req_rise & cfg_q[F_EXZ]);
    end
  end

  assign cfg_rdata = CFG_W'(cfg_q);
  assign zs_off    = cfg_q[F_ZOFF];
  assign bpv_arm   = bpv_pend & cfg_q[F_BPV];
  assign exz_arm   = exz_pend & cfg_q[F_EXZ];
endmodule

// File: rtl/ble_subst.sv
`timescale 1ns/1ps
module ble_subst
  import ble_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic hdb3,
  input  logic zs_off,
  input  logic exz_arm,
  output sym_t out_sym,
  output logic exz_take
);
  sym_t slot_q [LINE_DEPTH];
  sym_t slot_d [LINE_DEPTH];
  logic par_q;
  logic run_full, subst_hit;
  int   last_idx;

  assign last_idx = hdb3 ? LINE_DEPTH - 1 : LINE_DEPTH - 2;
  assign out_sym  = slot_q[last_idx];

  // the incoming zero completes a run of substitutable zeros
  assign run_full  = !in_bit && slot_q[0] == SYM_ZERO && slot_q[1] == SYM_ZERO &&
                     (hdb3 ? slot_q[2] == SYM_ZERO : 1'b1);
  assign subst_hit = in_valid && !zs_off && run_full;
  assign exz_take  = subst_hit && exz_arm;

  always_comb begin
    slot_d[0] = in_bit ? SYM_MARK : SYM_ZERO;
    for (int k = 1; k < LINE_DEPTH; k++) slot_d[k] = slot_q[k-1];
    if (subst_hit) begin
      if (exz_take) begin
        for (int k = 0; k < LINE_DEPTH; k++)
          if (k <= last_idx) slot_d[k] = SYM_HOLD;
      end else begin
        slot_d[0] = SYM_VIOL;
        if (!par_q) slot_d[last_idx] = SYM_BIP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LINE_DEPTH; k++) slot_q[k] <= SYM_HOLD;
      par_q <= 1'b0;
    end else if (in_valid) begin
      for (int k = 0; k < LINE_DEPTH; k++) slot_q[k] <= slot_d[k];
      if (subst_hit && !exz_take) par_q <= 1'b0;
      else if (in_bit)            par_q <= ~par_q;
    end
  end
endmodule

// File: rtl/ble_ami.sv
`timescale 1ns/1ps
module ble_ami
  import ble_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  sym_t sym,
  input  logic bpv_arm,
  output logic bpv_take,
  output logic pos_o,
  output logic neg_o,
  output logic vld_o
);
  logic last_pos, pulse, same, pol;

  assign bpv_take = in_valid && sym == SYM_MARK && bpv_arm;
  assign pulse    = sym == SYM_MARK || sym == SYM_BIP || sym == SYM_VIOL;
  assign same     = sym == SYM_VIOL || bpv_take;
  assign pol      = same ? last_pos : ~last_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos <= 1'b0;
      pos_o    <= 1'b0;
      neg_o    <= 1'b0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= in_valid;
      if (in_valid) begin
        pos_o <= pulse & pol;
        neg_o <= pulse & ~pol;
        if (pulse) last_pos <= pol;
      end else begin
        pos_o <= 1'b0;
        neg_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bipolar_line_encoder.sv
`timescale 1ns/1ps
module bipolar_line_encoder
  import ble_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             line_hdb3,
  input  logic             manual_err,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             pos_out,
  output logic             neg_out,
  output logic             out_valid
);
  logic zs_off, bpv_arm, exz_arm, bpv_take, exz_take;
  sym_t line_sym;

  ble_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .manual_err(manual_err), .bpv_take(bpv_take), .exz_take(exz_take),
    .cfg_rdata(cfg_rdata), .zs_off(zs_off), .bpv_arm(bpv_arm), .exz_arm(exz_arm)
  );

  ble_subst u_subst (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .hdb3(line_hdb3), .zs_off(zs_off), .exz_arm(exz_arm),
    .out_sym(line_sym), .exz_take(exz_take)
  );

  ble_ami u_ami (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sym(line_sym),
    .bpv_arm(bpv_arm), .bpv_take(bpv_take),
    .pos_o(pos_out), .neg_o(neg_out), .vld_o(out_valid)
  );
endmodule

// File: rtl/ble_checker.sv
`timescale 1ns/1ps
module ble_checker #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             in_valid,
  input logic             pos_out,
  input logic             neg_out,
  input logic             out_valid
);
  logic [2:0] calm_cnt;
  logic       seen_pos;
  logic       ami_only;
  logic       unused_chk_hi;

  assign unused_chk_hi = ^cfg_wdata[CFG_W-1:5];
  assign ami_only = cfg_rdata[4] && !cfg_rdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      calm_cnt <= '0;
      seen_pos <= 1'b0;
    end else begin
      if (!ami_only)                      calm_cnt <= '0;
      else if (in_valid && calm_cnt != 3'd5) calm_cnt <= calm_cnt + 3'd1;
      if (out_valid && (pos_out || neg_out)) seen_pos <= pos_out;
    end
  end

  AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pos_out && neg_out)); // R3
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!pos_out && !neg_out)); // R3
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R3
  AST_RDATA_PAD: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata >> 5) == '0); // R2
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata[4:0] == $past(cfg_wdata[4:0])); // R2
  AST_AMI_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (ami_only && calm_cnt == 3'd5 && out_valid && (pos_out || neg_out)) |->
      (pos_out != seen_pos)); // R4
endmodule

bind bipolar_line_encoder ble_checker #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .in_valid(in_valid), .pos_out(pos_out),
  .neg_out(neg_out), .out_valid(out_valid)
);

// File: tb/tb_bipolar_line_encoder.sv
`timescale 1ns/1ps
module tb_bipolar_line_encoder;
  localparam int CFG_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [CFG_W-1:0] cfg_rdata;
  logic line_hdb3 = 1'b0;
  logic manual_err = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic pos_out, neg_out, out_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  bipolar_line_encoder #(.CFG_W(CFG_W)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .line_hdb3(line_hdb3), .manual_err(manual_err),
    .in_valid(in_valid), .in_bit(in_bit), .pos_out(pos_out),
    .neg_out(neg_out), .out_valid(out_valid)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected symbol per output strobe
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected output symbol", 1, 0);
        end else begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({pos_out, neg_out} == e, t, "rails {pos,neg}",
                int'({pos_out, neg_out}), int'(e));
        end
      end
    end
  end

  task automatic do_reset(input bit hdb3);
    @(negedge clk);
    rst = 1'b1;
    line_hdb3 = hdb3;
    manual_err = 1'b0;
    in_valid = 1'b0;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_write(input logic [CFG_W-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pin_pulse();
    @(negedge clk);
    manual_err = 1'b1;
    @(negedge clk);
    manual_err = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // driver: builds the expected line code from the requirements and streams bits
  task automatic run_case(input string bits, input bit zoff, input bit bpv_p,
                          input bit exz_p, input string req);
    int n, nrun, zc, s;
    int sy[72];
    bit par, exz_left, bpv_left, last_pos, pol;
    n = bits.len();
    nrun = line_hdb3 ? 4 : 3;
    for (int i = 0; i < 72; i++) sy[i] = 0;
    zc = 0; par = 1'b0; exz_left = exz_p;
    for (int i = 0; i < n; i++) begin
      if (bits[i] == 8'h31) begin
        sy[i] = 1; par = ~par; zc = 0;
      end else begin
        zc++;
        if (!zoff && zc == nrun) begin
          if (exz_left) exz_left = 1'b0;
          else begin
            sy[i] = 3;
            if (!par) sy[i-nrun+1] = 2;
            par = 1'b0;
          end
          zc = 0;
        end
      end
    end
    last_pos = 1'b0; bpv_left = bpv_p;
    for (int j = 0; j < n; j++) begin
      s = (j < nrun) ? 0 : sy[j-nrun];
      if (s == 0) exp_q.push_back(2'b00);
      else begin
        if (s == 3 || (s == 1 && bpv_left)) begin
          pol = last_pos;
          if (s == 1) bpv_left = 1'b0;
        end else begin
          pol = ~last_pos;
          last_pos = pol;
        end
        exp_q.push_back({pol, ~pol});
      end
      tag_q.push_back(req);
    end
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit = (bits[j] == 8'h31);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3", "symbols still owed", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    #1;
    check(cfg_rdata == '0, "R1", "cfg_rdata after reset", int'(cfg_rdata), 0);
    check(!out_valid && !pos_out && !neg_out, "R1", "outputs after reset",
          int'({out_valid, pos_out, neg_out}), 0);

    // R2 register readback with upper bits forced low
    cfg_write(8'hFF);
    check(cfg_rdata == 8'h1F, "R2", "readback of 0xFF", int'(cfg_rdata), 31);
    cfg_write(8'h0A);
    check(cfg_rdata == 8'h0A, "R2", "readback of 0x0A", int'(cfg_rdata), 10);

    // R4 plain alternating marks, substitution off (R1 idle slots at start)
    do_reset(1'b0);
    cfg_write(8'h10);
    run_case("1100010000100000011", 1'b1, 1'b0, 1'b0, "R4");

    // R5 three-zero substitution, odd and even pulse counts
    do_reset(1'b0);
    run_case("1000100001100000010100011000111", 1'b0, 1'b0, 1'b0, "R5");

    // R6 four-zero substitution
    do_reset(1'b1);
    run_case("1000010000000011000001100000000100111", 1'b0, 1'b0, 1'b0, "R6");

    // R7 and R9: several rises of the request bit, one violation only
    do_reset(1'b0);
    cfg_write(8'h16);
    cfg_write(8'h14);
    cfg_write(8'h16);
    cfg_write(8'h14);
    run_case("1011011", 1'b1, 1'b1, 1'b0, "R9");

    // R8 and R10: pin request gives one raw zero run
    do_reset(1'b1);
    cfg_write(8'h09);
    pin_pulse();
    run_case("10000100001011110000111", 1'b0, 1'b0, 1'b1, "R8");

    // R10: pin ignored while the register source is selected
    do_reset(1'b1);
    cfg_write(8'h0C);
    pin_pulse();
    run_case("1100001000011", 1'b0, 1'b0, 1'b0, "R10");

    // R11: request with both enables clear changes nothing
    do_reset(1'b1);
    cfg_write(8'h02);
    run_case("11000010000101", 1'b0, 1'b0, 1'b0, "R11");

    // R12: switching the source while the pin is high raises a request
    do_reset(1'b0);
    cfg_write(8'h04);
    @(negedge clk);
    manual_err = 1'b1;
    repeat (3) @(negedge clk);
    cfg_write(8'h05);
    run_case("110101", 1'b0, 1'b1, 1'b0, "R12");
    manual_err = 1'b0;

    // R13: one request, both error kinds
    do_reset(1'b1);
    cfg_write(8'h0E);
    run_case("1100001011000011", 1'b0, 1'b1, 1'b1, "R13");

    done = 1'b1;
    finish_run();
  end
endmodule